// File: doc/BRIEF.md
# SPI Wiper Control Slave

This block is the serial-side controller of a digitally set resistor-ladder wiper. A host reaches it over a four-wire SPI-style bus (clock, select, data in, data out) plus a pause line and a write-guard line. Every transaction is three bytes. The first byte is a device address. Its low bit must equal a board-strapped input, which lets two such slaves share one bus. The second byte is an instruction. The third byte carries write data, or it carries the read reply on the serial output.

The block keeps a wiper position register and a small bank of stored positions. The bank stands in for nonvolatile memory. Each write into the bank starts a fixed-length busy period. The wiper position is decoded into a one-hot tap select for the ladder. All bus pins are sampled on the system clock and are expected to be synchronous to it. The serial clock must run at least two system clocks per phase.

Top module: `wiper_spi_slave`

## Requirements
- R1: After reset the tap select has only bit 0 set, the serial output enable is low, and every stored position is 0.
- R2: After reset, bus activity is ignored until chip select (active low) has gone from high to low at least once.
- R3: The first byte must be 0101_000x, where x equals the address-strap input. On any other value the rest of the transaction has no effect and the serial output stays disabled.
- R4: Instruction byte bits 7:4 = 1010 loads the wiper register from bits 5:0 of the third byte at the end of that byte.
- R5: Instruction 1001 (read wiper) or 1011 (read stored position) enables the serial output for the third byte only. The output sends two zero bits and then the 6-bit value, MSB first. Each bit is valid at the serial-clock rising edge and changes on the falling edge. The output is disabled whenever chip select is high.
- R6: Instruction 1100 writes bits 5:0 of the third byte into the stored position chosen by instruction bits 3:2, and starts a busy period of BUSY_CYCLES system clocks.
- R7: While the write-guard input is low, writes to stored positions (1100 and 1110) are dropped and start no busy period. Wiper writes are still accepted.
- R8: Instruction 1101 copies the chosen stored position into the wiper register. Instruction 1110 copies the wiper register into the chosen stored position and starts a busy period. Both take effect at the end of the instruction byte.
- R9: An instruction byte that completes during a busy period is ignored, together with the rest of its transaction.
- R10: Hold low, applied while the serial clock is low, pauses the interface. Serial-clock edges during the pause are ignored. Hold high, applied while the clock is low, resumes the transaction with no bits lost.
- R11: Chip select rising before a byte is complete aborts the transaction. The partial byte has no effect, and the next transaction starts from a fresh address byte.
- R12: The tap select output always has exactly one bit set: the bit whose index equals the wiper register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Chip select, active low |
| hold_n_i | input | 1 | Pause request, active low |
| si_i | input | 1 | Serial data in |
| wp_n_i | input | 1 | Write guard for stored positions, active low |
| addr_strap_i | input | 1 | Strapped low bit of the device address |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Serial output drive enable (low = high impedance) |
| tap_sel_o | output | 64 | One-hot ladder tap select |

## Verification
Two events can fall into the same system-clock cycle. One is the end of a stored-position write's busy period. The other is the completion of a new instruction byte, which the busy timer must then reject. The bench provokes this by issuing a wiper write right after a stored-position write, so that the instruction byte ends while the timer is still counting. Its cycle-accurate model counts clocks from the write and decides whether the instruction is dropped, and the tap select is compared against the model on every clock. A second pairing puts a hold pause and a chip-select or serial-clock edge in the same cycle. The bench judges it by whether the paused transaction still lands its data.

// File: rtl/wsi_pkg.sv
package wsi_pkg;
   typedef enum logic [1:0] {
      PH_ADDR   = 2'd0,
      PH_INSTR  = 2'd1,
      PH_DATA   = 2'd2,
      PH_IGNORE = 2'd3
   } phase_e;

   localparam logic [3:0] OP_RD_WIPER   = 4'b1001;
   localparam logic [3:0] OP_WR_WIPER   = 4'b1010;
   localparam logic [3:0] OP_RD_STORE   = 4'b1011;
   localparam logic [3:0] OP_WR_STORE   = 4'b1100;
   localparam logic [3:0] OP_LOAD_WIPER = 4'b1101;
   localparam logic [3:0] OP_SAVE_WIPER = 4'b1110;
endpackage

// File: rtl/wsi_bus_front.sv
module wsi_bus_front (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic cs_n_i,
   input  logic hold_n_i,
   output logic sck_rise_o,
   output logic sck_fall_o,
   output logic cs_rise_o,
   output logic armed_o,
   output logic paused_o
);
   logic sck_q, cs_q, armed_q, paused_q, active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         cs_q     <= 1'b0;
         armed_q  <= 1'b0;
         paused_q <= 1'b0;
      end else begin
         sck_q <= sck_i;
         cs_q  <= cs_n_i;
         if (cs_q && !cs_n_i)
            armed_q <= 1'b1;
         if (cs_n_i)
            paused_q <= 1'b0;
         else if (!sck_i)
            paused_q <= !hold_n_i;
      end
   end

   always_comb begin
      active     = armed_q && !cs_n_i && !paused_q;
      sck_rise_o = active && sck_i && !sck_q;
      sck_fall_o = active && !sck_i && sck_q;
      cs_rise_o  = !cs_q && cs_n_i;
      armed_o    = armed_q;
      paused_o   = paused_q;
   end
endmodule

// File: rtl/wsi_serial_engine.sv
module wsi_serial_engine
   import wsi_pkg::*;
#(
   parameter int          WIPER_W = 6,
   parameter int          NUM_DR  = 4,
   parameter logic [3:0]  DEV_ID  = 4'b0101,
   localparam int         IDX_W   = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_rise_i,
   input  logic               sck_fall_i,
   input  logic               cs_rise_i,
   input  logic               armed_i,
   input  logic               paused_i,
   input  logic               si_i,
   input  logic               strap_i,
   input  logic               busy_i,
   input  logic [WIPER_W-1:0] wiper_i,
   input  logic [WIPER_W-1:0] store_i,
   output logic [IDX_W-1:0]   idx_o,
   output logic [WIPER_W-1:0] data_o,
   output logic               wr_wiper_o,
   output logic               wr_store_o,
   output logic               load_wiper_o,
   output logic               save_wiper_o,
   output logic               so_o,
   output logic               so_en_o
);
   phase_e             phase_q;
   logic [2:0]         bit_cnt_q;
   logic [6:0]         in_sr_q;
   logic [7:0]         out_sr_q;
   logic [3:0]         op_q;
   logic [IDX_W-1:0]   idx_q;
   logic               rd_mode_q;

   logic [7:0]         byte_full;
   logic [3:0]         op_now;
   logic               byte_done, addr_hit, instr_ok, data_end;
   logic               now_read, now_write;

   always_comb begin
      byte_full    = {in_sr_q, si_i};
      op_now       = byte_full[7:4];
      byte_done    = sck_rise_i && (bit_cnt_q == 3'd7);
      addr_hit     = (byte_full == {DEV_ID, 3'b000, strap_i});
      instr_ok     = byte_done && (phase_q == PH_INSTR) && !busy_i;
      data_end     = byte_done && (phase_q == PH_DATA);
      now_read     = (op_now == OP_RD_WIPER) || (op_now == OP_RD_STORE);
      now_write    = (op_now == OP_WR_WIPER) || (op_now == OP_WR_STORE);
      idx_o        = (phase_q == PH_INSTR) ? byte_full[2 +: IDX_W] : idx_q;
      data_o       = byte_full[WIPER_W-1:0];
      wr_wiper_o   = data_end && (op_q == OP_WR_WIPER);
      wr_store_o   = data_end && (op_q == OP_WR_STORE);
      load_wiper_o = instr_ok && (op_now == OP_LOAD_WIPER);
      save_wiper_o = instr_ok && (op_now == OP_SAVE_WIPER);
      so_o         = out_sr_q[7];
      so_en_o      = (phase_q == PH_DATA) && rd_mode_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_ADDR;
         bit_cnt_q <= 3'd0;
         in_sr_q   <= 7'd0;
         out_sr_q  <= 8'd0;
         op_q      <= 4'd0;
         idx_q     <= '0;
         rd_mode_q <= 1'b0;
      end else if (cs_rise_i || !armed_i) begin
         phase_q   <= PH_ADDR;
         bit_cnt_q <= 3'd0;
         out_sr_q  <= 8'd0;
         rd_mode_q <= 1'b0;
      end else if (sck_rise_i) begin
         in_sr_q   <= byte_full[6:0];
         bit_cnt_q <= bit_cnt_q + 3'd1;
         if (byte_done) begin
            unique case (phase_q)
               PH_ADDR:  phase_q <= addr_hit ? PH_INSTR : PH_IGNORE;
               PH_INSTR: begin
                  if (instr_ok && (now_read || now_write)) begin
                     phase_q   <= PH_DATA;
                     op_q      <= op_now;
                     idx_q     <= byte_full[2 +: IDX_W];
                     rd_mode_q <= now_read;
                     out_sr_q  <= 8'((op_now == OP_RD_WIPER) ? wiper_i : store_i);
                  end else begin
                     phase_q <= PH_IGNORE;
                  end
               end
               PH_DATA: begin
                  phase_q   <= PH_IGNORE;
                  rd_mode_q <= 1'b0;
               end
               default: phase_q <= PH_IGNORE;
            endcase
         end
      end else if (sck_fall_i && (phase_q == PH_DATA) && rd_mode_q && (bit_cnt_q != 3'd0)) begin
         out_sr_q <= {out_sr_q[6:0], 1'b0};
      end
   end

   // R2: nothing advances before the first chip-select fall
   p_lockout_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_i |=> (bit_cnt_q == 3'd0) && (phase_q == PH_ADDR));

   // R9: an instruction completing while busy never opens a data phase
   p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && byte_done && (phase_q == PH_INSTR) && !cs_rise_i && armed_i)
      |=> (phase_q == PH_IGNORE));

   // R10: a pause freezes the bit position
   p_pause_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (paused_i && !cs_rise_i) |=> $stable(bit_cnt_q));
endmodule

// File: rtl/wsi_regfile.sv
module wsi_regfile #(
   parameter int  WIPER_W     = 6,
   parameter int  NUM_DR      = 4,
   parameter int  BUSY_CYCLES = 1000,
   localparam int IDX_W       = (NUM_DR > 1) ? $clog2(NUM_DR) : 1,
   localparam int BUSY_W      = $clog2(BUSY_CYCLES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wp_n_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic [WIPER_W-1:0] data_i,
   input  logic               wr_wiper_i,
   input  logic               wr_store_i,
   input  logic               load_wiper_i,
   input  logic               save_wiper_i,
   output logic [WIPER_W-1:0] wiper_o,
   output logic [WIPER_W-1:0] store_o,
   output logic               busy_o
);
   logic [WIPER_W-1:0]        wiper_q;
   logic [WIPER_W-1:0]        store_q [NUM_DR];
   logic [NUM_DR*WIPER_W-1:0] store_flat;
   logic [BUSY_W-1:0]         busy_cnt_q;
   logic                      nv_write;

   assign nv_write = wp_n_i && (wr_store_i || save_wiper_i);

   for (genvar i = 0; i < NUM_DR; i++) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            store_q[i] <= '0;
         else if (nv_write && (idx_i == IDX_W'(i)))
            store_q[i] <= wr_store_i ? data_i : wiper_q;
      end
      assign store_flat[i*WIPER_W +: WIPER_W] = store_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wiper_q <= '0;
      else if (wr_wiper_i)
         wiper_q <= data_i;
      else if (load_wiper_i)
         wiper_q <= store_q[idx_i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy_cnt_q <= '0;
      else if (nv_write)
         busy_cnt_q <= BUSY_W'(BUSY_CYCLES);
      else if (busy_cnt_q != '0)
         busy_cnt_q <= busy_cnt_q - 1'b1;
   end

   assign wiper_o = wiper_q;
   assign store_o = store_q[idx_i];
   assign busy_o  = (busy_cnt_q != '0);

   // R7: with the guard low, stored positions never change
   p_guard_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n_i |=> (store_flat == $past(store_flat)));

   // R6: an accepted stored write raises busy on the next cycle
   p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_n_i && wr_store_i) |=> busy_o);
endmodule

// File: rtl/wsi_tap_decode.sv
module wsi_tap_decode #(
   parameter int  WIPER_W = 6,
   localparam int TAPS    = 1 << WIPER_W
) (
   input  logic [WIPER_W-1:0] code_i,
   output logic [TAPS-1:0]    tap_o
);
   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap_o[t] = (code_i == WIPER_W'(t));
   end
endmodule

// File: rtl/wiper_spi_slave.sv
module wiper_spi_slave #(
   parameter int         WIPER_W     = 6,
   parameter int         NUM_DR      = 4,
   parameter int         BUSY_CYCLES = 1000,
   parameter logic [3:0] DEV_ID      = 4'b0101,
   localparam int        TAPS        = 1 << WIPER_W,
   localparam int        IDX_W       = (NUM_DR > 1) ? $clog2(NUM_DR) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sck_i,
   input  logic            cs_n_i,
   input  logic            hold_n_i,
   input  logic            si_i,
   input  logic            wp_n_i,
   input  logic            addr_strap_i,
   output logic            so_o,
   output logic            so_en_o,
   output logic [TAPS-1:0] tap_sel_o
);
   if (WIPER_W < 1 || WIPER_W > 6) begin : g_bad_width
      $error("WIPER_W must be 1..6 to fit the data byte");
   end
   if (NUM_DR < 2 || NUM_DR > 4 || (NUM_DR & (NUM_DR - 1)) != 0) begin : g_bad_depth
      $error("NUM_DR must be 2 or 4 (two-bit index field)");
   end
   if (BUSY_CYCLES < 1) begin : g_bad_busy
      $error("BUSY_CYCLES must be at least 1");
   end

   logic               sck_rise, sck_fall, cs_rise, armed, paused, busy;
   logic               wr_wiper, wr_store, load_wiper, save_wiper;
   logic [IDX_W-1:0]   idx;
   logic [WIPER_W-1:0] wdata, wiper, store;

   wsi_bus_front u_front (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_i      (sck_i),
      .cs_n_i     (cs_n_i),
      .hold_n_i   (hold_n_i),
      .sck_rise_o (sck_rise),
      .sck_fall_o (sck_fall),
      .cs_rise_o  (cs_rise),
      .armed_o    (armed),
      .paused_o   (paused)
   );

   wsi_serial_engine #(.WIPER_W(WIPER_W), .NUM_DR(NUM_DR), .DEV_ID(DEV_ID)) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_rise_i   (sck_rise),
      .sck_fall_i   (sck_fall),
      .cs_rise_i    (cs_rise),
      .armed_i      (armed),
      .paused_i     (paused),
      .si_i         (si_i),
      .strap_i      (addr_strap_i),
      .busy_i       (busy),
      .wiper_i      (wiper),
      .store_i      (store),
      .idx_o        (idx),
      .data_o       (wdata),
      .wr_wiper_o   (wr_wiper),
      .wr_store_o   (wr_store),
      .load_wiper_o (load_wiper),
      .save_wiper_o (save_wiper),
      .so_o         (so_o),
      .so_en_o      (so_en_o)
   );

   wsi_regfile #(.WIPER_W(WIPER_W), .NUM_DR(NUM_DR), .BUSY_CYCLES(BUSY_CYCLES)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wp_n_i       (wp_n_i),
      .idx_i        (idx),
      .data_i       (wdata),
      .wr_wiper_i   (wr_wiper),
      .wr_store_i   (wr_store),
      .load_wiper_i (load_wiper),
      .save_wiper_i (save_wiper),
      .wiper_o      (wiper),
      .store_o      (store),
      .busy_o       (busy)
   );

   wsi_tap_decode #(.WIPER_W(WIPER_W)) u_taps (
      .code_i (wiper),
      .tap_o  (tap_sel_o)
   );

   // R5: output stays released while chip select is high
   p_so_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cs_n_i) && cs_n_i) |-> !so_en_o);

   // R12: exactly one tap is selected
   p_one_tap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel_o) == 1);
endmodule

// File: tb/wiper_spi_slave_test.sv
module wiper_spi_slave_test;
   localparam int BUSY  = 40;
   localparam int LIMIT = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1, si = 1'b0, wp_n = 1'b1;
   logic strap = 1'b1;
   logic so_o, so_en_o;
   logic [63:0] tap_sel_o;

   wiper_spi_slave #(.BUSY_CYCLES(BUSY)) uut (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
      .si_i(si), .wp_n_i(wp_n), .addr_strap_i(strap),
      .so_o(so_o), .so_en_o(so_en_o), .tap_sel_o(tap_sel_o));

   always #5 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0, busy_start = -100000;
   bit done = 0;
   int m_wiper = 0;
   int m_store [4] = '{0, 0, 0, 0};
   bit m_so_en = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > LIMIT && !done) begin
         fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, LIMIT);
         finish_run();
      end
   end

   // per-clock comparison against the model (R12 tap, R5 enable)
   always @(posedge clk) begin
      #3;
      if (rst_n && !done) begin
         chk("R12", tap_sel_o, 64'd1 << m_wiper);
         chk("R5", {63'd0, so_en_o}, {63'd0, m_so_en});
      end
   end

   task automatic put_bit(input logic b, output logic seen);
      @(negedge clk);
      si = b;
      seen = so_o;
      sck = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic end_bit;
      @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic pause_here;
      @(negedge clk);
      hold_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); sck = 1'b1; si = ~si;
         @(negedge clk); sck = 1'b0;
      end
      @(negedge clk);
      hold_n = 1'b1;
   endtask

   task automatic txn(input logic [7:0] ab, input logic [7:0] ib, input logic [7:0] db,
                      input int data_bits, input int hold_bit, output logic [7:0] rd);
      logic matched, go_data, seen;
      logic [3:0] op;
      int idx;
      matched = (ab[7:1] == 7'b0101_000) && (ab[0] == strap);
      op = ib[7:4];
      idx = int'(ib[3:2]);
      go_data = 0;
      rd = 8'h00;
      @(negedge clk);
      cs_n = 1'b0;
      for (int n = 0; n < 8 + 8 + data_bits; n++) begin
         logic b;
         if (n == hold_bit) pause_here();
         b = (n < 8) ? ab[7 - n] : (n < 16) ? ib[15 - n] : db[23 - n];
         put_bit(b, seen);
         if (n >= 16) rd[23 - n] = seen;
         if (n == 15 && matched && (cyc - busy_start) > BUSY) begin
            if (op == 4'b1001 || op == 4'b1011) begin
               go_data = 1; m_so_en = 1;
            end else if (op == 4'b1010 || op == 4'b1100) begin
               go_data = 1;
            end else if (op == 4'b1101) begin
               m_wiper = m_store[idx];
            end else if (op == 4'b1110 && wp_n) begin
               m_store[idx] = m_wiper; busy_start = cyc;
            end
         end
         if (n == 23 && go_data) begin
            m_so_en = 0;
            if (op == 4'b1010) m_wiper = int'(db[5:0]);
            if (op == 4'b1100 && wp_n) begin
               m_store[idx] = int'(db[5:0]); busy_start = cyc;
            end
         end
         end_bit();
      end
      @(negedge clk);
      cs_n = 1'b1;
      @(posedge clk);
      #1;
      m_so_en = 0;
      @(negedge clk);
   endtask

   task automatic wait_idle;
      repeat (BUSY + 10) @(negedge clk);
   endtask

   logic [7:0] r;

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", tap_sel_o, 64'd1);
      chk("R1", {63'd0, so_en_o}, 64'd0);

      // R2: chip select held low since reset, full write attempt ignored
      for (int n = 0; n < 24; n++) begin
         logic seen;
         logic [23:0] w = {8'h51, 8'hA0, 8'h21};
         put_bit(w[23 - n], seen);
         end_bit();
      end
      repeat (3) @(negedge clk);
      chk("R2", tap_sel_o, 64'd1);
      cs_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: stored positions start at 0
      txn(8'h51, 8'hB0, 8'h00, 8, -1, r);
      chk("R1", {56'd0, r}, 64'd0);

      // R4: wiper write
      txn(8'h51, 8'hA0, 8'h2D, 8, -1, r);
      chk("R4", tap_sel_o, 64'd1 << 45);

      // R5: wiper read
      txn(8'h51, 8'h90, 8'h00, 8, -1, r);
      chk("R5", {56'd0, r}, 64'd45);

      // R3: strap mismatch and wrong high nibble
      txn(8'h50, 8'hA0, 8'h07, 8, -1, r);
      chk("R3", tap_sel_o, 64'd1 << 45);
      txn(8'h61, 8'h90, 8'h00, 8, -1, r);
      chk("R3", {63'd0, so_en_o}, 64'd0);

      // R6 then R9: stored write, then a wiper write inside the busy window
      txn(8'h51, 8'hC8, 8'h11, 8, -1, r);
      txn(8'h51, 8'hA0, 8'h09, 8, -1, r);
      chk("R9", tap_sel_o, 64'd1 << 45);
      wait_idle();
      txn(8'h51, 8'hB8, 8'h00, 8, -1, r);
      chk("R6", {56'd0, r}, 64'd17);

      // R7: guard low blocks stored writes, not wiper writes
      wp_n = 1'b0;
      txn(8'h51, 8'hC4, 8'h16, 8, -1, r);
      txn(8'h51, 8'hA0, 8'h0B, 8, -1, r);
      chk("R7", tap_sel_o, 64'd1 << 11);
      txn(8'h51, 8'hE0, 8'h00, 8, -1, r);
      txn(8'h51, 8'hB4, 8'h00, 8, -1, r);
      chk("R7", {56'd0, r}, 64'd0);
      txn(8'h51, 8'hB0, 8'h00, 8, -1, r);
      chk("R7", {56'd0, r}, 64'd0);
      wp_n = 1'b1;

      // R8: load wiper from store 2, save wiper into store 3
      txn(8'h51, 8'hD8, 8'h00, 8, -1, r);
      chk("R8", tap_sel_o, 64'd1 << 17);
      txn(8'h51, 8'hA0, 8'h03, 8, -1, r);
      txn(8'h51, 8'hEC, 8'h00, 8, -1, r);
      wait_idle();
      txn(8'h51, 8'hBC, 8'h00, 8, -1, r);
      chk("R8", {56'd0, r}, 64'd3);

      // R10: pauses in the address byte and in the data byte
      txn(8'h51, 8'hA0, 8'h32, 8, 4, r);
      chk("R10", tap_sel_o, 64'd1 << 50);
      txn(8'h51, 8'hA0, 8'h15, 8, 19, r);
      chk("R10", tap_sel_o, 64'd1 << 21);

      // R11: abort after three data bits, then a clean transaction
      txn(8'h51, 8'hA0, 8'h3F, 3, -1, r);
      chk("R11", tap_sel_o, 64'd1 << 21);
      txn(8'h51, 8'hA0, 8'h3F, 8, -1, r);
      chk("R11", tap_sel_o, 64'd1 << 63);
      txn(8'h51, 8'h90, 8'h00, 8, -1, r);
      chk("R5", {56'd0, r}, 64'd63);
      txn(8'h51, 8'hA0, 8'h00, 8, -1, r);
      chk("R12", tap_sel_o, 64'd1);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule